// File: doc/BRIEF.md
# TDM Transmit Channel Table Sequencer

This block decides which TDM channels reach the transmit buffers in external memory. A control table in that memory holds one 16-bit word per transmit circular buffer. On each frame-start pulse the sequencer reads the table from its first word to its last through a request/acknowledge read port. Each word names a stream and a time slot. A word whose top bit is set becomes a transfer command. The command carries the channel selection, the buffer number and the byte address of that 64-byte buffer.

The position of a word in the table fixes the destination buffer. Its content only picks the source channel. A word with the top bit clear still uses up its buffer number, but it produces no command. The table base address is always 512-byte aligned, so only its upper bits are programmable. The table length is clamped into the supported range. The base, the length and the buffer-area base are sampled when the frame starts, so any change to them takes effect on the next frame.

Top module: `tdm_tx_table_seq`

## Requirements
- R1: After a synchronous reset the block is idle at entry 0. It makes no memory request, shows no command and has the error flag clear, and it stays idle until a frame-start pulse arrives.
- R2: The read address for entry n is {tbl_base_hi, 9'b0} + 2·n, modulo 2^21. Only one read is outstanding at a time, and mem_req and mem_addr hold steady until mem_ack.
- R3: A frame-start pulse in idle begins a walk at entry 0. The entries are read in ascending order, each exactly once per frame.
- R4: A word with bit 15 set yields a command with cmd_stream = bits 3:0, cmd_slot = bits 10:4 and cmd_index = n.
- R5: A word with bit 15 clear yields no command, and the walk moves on to entry n+1.
- R6: cmd_addr = buf_base + 64·n, modulo 2^21.
- R7: The effective length is tbl_len clamped to the range 128 to 2048. A walk reads exactly that many entries, and every command index is below it.
- R8: After the last entry the block stays idle until the next frame-start pulse. A frame-start pulse during a walk has no effect.
- R9: While cmd_valid is high and cmd_ready is low, the command stays valid with unchanged fields and no further read is issued.
- R10: Bits 14:11 play no part in decoding. If any of them is nonzero in a fetched word, rsvd_err sets and stays set until reset.
- R11: tbl_base_hi, tbl_len and buf_base are sampled at the frame-start pulse that begins a walk. Changes made during the walk have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse that starts a table walk |
| tbl_base_hi | input | 12 | Table base address bits 20:9 |
| tbl_len | input | 12 | Requested table entry count (clamped) |
| buf_base | input | 21 | Byte address of transmit buffer 0 |
| mem_req | output | 1 | Read request |
| mem_addr | output | 21 | Read byte address |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Table word |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_stream | output | 4 | Source stream number |
| cmd_slot | output | 7 | Source time slot |
| cmd_index | output | 11 | Destination buffer number |
| cmd_addr | output | 21 | Destination buffer byte address |
| rsvd_err | output | 1 | Sticky flag for nonzero reserved bits |

## Verification
The walk is tried with four table contents. In the first, every word is valid, which shows that commands line up with read order. In the second, alternate words are valid, and in the third only every fifth word is, which shows that an invalid word consumes its buffer number. The fourth puts nonzero reserved bits in valid words, which shows that decoding ignores them while the flag sets. These contents run under a zero or nonzero read latency and a stalling or always-ready command sink, so that holding behaviour can be told apart from sequencing. Length values below, inside and above the legal range, together with a base near the top of the address space, distinguish clamping and address wrap. A mid-walk change of the configuration, plus a stray frame-start pulse, separates the sampled configuration from the live one.

// File: rtl/ttseq_pkg.sv
package ttseq_pkg;
   localparam int unsigned WORD_W   = 16;
   localparam int unsigned SLOT_W   = 7;
   localparam int unsigned STREAM_W = 4;
   localparam int unsigned RSVD_W   = 4;

   typedef struct packed {
      logic                vld;
      logic [RSVD_W-1:0]   rsvd;
      logic [SLOT_W-1:0]   slot;
      logic [STREAM_W-1:0] stream;
   } tbl_word_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_CMD  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/ttseq_cfg.sv
module ttseq_cfg #(
   parameter int unsigned ADDR_W     = 21,
   parameter int unsigned ALIGN_BITS = 9,
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned MIN_LEN    = 128,
   parameter int unsigned MAX_LEN    = 2048,
   parameter bit          LATCH_CFG  = 1'b1,
   localparam int unsigned HI_W      = ADDR_W - ALIGN_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [HI_W-1:0]   base_hi,
   input  logic [LEN_W-1:0]  len_raw,
   input  logic [ADDR_W-1:0] buf_raw,
   output logic [ADDR_W-1:0] tbl_base,
   output logic [LEN_W-1:0]  len_eff,
   output logic [ADDR_W-1:0] buf_base
);
   logic [LEN_W-1:0]  len_clamped;
   logic [ADDR_W-1:0] base_full;

   assign base_full = {base_hi, {ALIGN_BITS{1'b0}}};

   always_comb begin
      if (len_raw < LEN_W'(MIN_LEN))      len_clamped = LEN_W'(MIN_LEN);
      else if (len_raw > LEN_W'(MAX_LEN)) len_clamped = LEN_W'(MAX_LEN);
      else                                len_clamped = len_raw;
   end

   generate
      if (LATCH_CFG) begin : g_latched
         logic [ADDR_W-1:0] base_q;
         logic [LEN_W-1:0]  len_q;
         logic [ADDR_W-1:0] buf_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               base_q <= '0;
               len_q  <= LEN_W'(MIN_LEN);
               buf_q  <= '0;
            end else if (load) begin
               base_q <= base_full;
               len_q  <= len_clamped;
               buf_q  <= buf_raw;
            end
         end
         assign tbl_base = base_q;
         assign len_eff  = len_q;
         assign buf_base = buf_q;
      end else begin : g_live
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst, load};
         assign tbl_base  = base_full;
         assign len_eff   = len_clamped;
         assign buf_base  = buf_raw;
      end
   endgenerate

   p_len_range_r7: assert property (@(posedge clk) disable iff (rst)
      (len_eff >= LEN_W'(MIN_LEN)) && (len_eff <= LEN_W'(MAX_LEN)));
endmodule

// File: rtl/ttseq_addr.sv
module ttseq_addr #(
   parameter int unsigned ADDR_W      = 21,
   parameter int unsigned IDX_W       = 11,
   parameter int unsigned ENTRY_BYTES = 2,
   parameter int unsigned BUF_BYTES   = 64,
   localparam int unsigned ENTRY_SH   = $clog2(ENTRY_BYTES),
   localparam int unsigned BUF_SH     = $clog2(BUF_BYTES)
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [ADDR_W-1:0] buf_base,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] dst_addr
);
   logic [ADDR_W-1:0] idx_w;
   assign idx_w    = ADDR_W'(idx);
   assign rd_addr  = tbl_base + (idx_w << ENTRY_SH);
   assign dst_addr = buf_base + (idx_w << BUF_SH);
endmodule

// File: rtl/ttseq_decode.sv
module ttseq_decode
   import ttseq_pkg::*;
(
   input  logic [WORD_W-1:0]   word,
   output logic                vld,
   output logic [SLOT_W-1:0]   slot,
   output logic [STREAM_W-1:0] stream,
   output logic                rsvd_bad
);
   tbl_word_t w;
   assign w        = tbl_word_t'(word);
   assign vld      = w.vld;
   assign slot     = w.slot;
   assign stream   = w.stream;
   assign rsvd_bad = |w.rsvd;
endmodule

// File: rtl/tdm_tx_table_seq.sv
module tdm_tx_table_seq
   import ttseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 21,
   parameter int unsigned ALIGN_BITS  = 9,
   parameter int unsigned MIN_LEN     = 128,
   parameter int unsigned MAX_LEN     = 2048,
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned ENTRY_BYTES = 2,
   parameter int unsigned BUF_BYTES   = 64,
   parameter bit          LATCH_CFG   = 1'b1,
   localparam int unsigned IDX_W      = $clog2(MAX_LEN),
   localparam int unsigned HI_W       = ADDR_W - ALIGN_BITS
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                frame_start,
   input  logic [HI_W-1:0]     tbl_base_hi,
   input  logic [LEN_W-1:0]    tbl_len,
   input  logic [ADDR_W-1:0]   buf_base,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic                mem_ack,
   input  logic [WORD_W-1:0]   mem_rdata,
   output logic                cmd_valid,
   input  logic                cmd_ready,
   output logic [STREAM_W-1:0] cmd_stream,
   output logic [SLOT_W-1:0]   cmd_slot,
   output logic [IDX_W-1:0]    cmd_index,
   output logic [ADDR_W-1:0]   cmd_addr,
   output logic                rsvd_err
);
   generate
      if (MIN_LEN > MAX_LEN) begin : g_chk_order
         $error("MIN_LEN exceeds MAX_LEN");
      end
      if (LEN_W <= IDX_W) begin : g_chk_lenw
         $error("LEN_W too narrow for MAX_LEN");
      end
      if ((1 << ALIGN_BITS) < ENTRY_BYTES * 2) begin : g_chk_align
         $error("alignment smaller than entry pair");
      end
      if ((1 << $clog2(BUF_BYTES)) != BUF_BYTES) begin : g_chk_buf
         $error("BUF_BYTES must be a power of two");
      end
      if ((1 << $clog2(ENTRY_BYTES)) != ENTRY_BYTES) begin : g_chk_ent
         $error("ENTRY_BYTES must be a power of two");
      end
   endgenerate

   seq_state_t          state;
   logic [IDX_W-1:0]    idx;
   logic [SLOT_W-1:0]   slot_q;
   logic [STREAM_W-1:0] stream_q;
   logic                err_q;

   logic [ADDR_W-1:0]   tbl_base_e;
   logic [LEN_W-1:0]    len_e;
   logic [ADDR_W-1:0]   buf_base_e;
   logic [ADDR_W-1:0]   rd_addr;
   logic [ADDR_W-1:0]   dst_addr;
   logic                dec_vld;
   logic [SLOT_W-1:0]   dec_slot;
   logic [STREAM_W-1:0] dec_stream;
   logic                dec_rsvd;
   logic                cfg_load;
   logic                at_last;

   assign cfg_load = (state == ST_IDLE) && frame_start;
   assign at_last  = (LEN_W'(idx) == (len_e - LEN_W'(1)));

   ttseq_cfg #(
      .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .LEN_W(LEN_W),
      .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LATCH_CFG(LATCH_CFG)
   ) u_cfg (
      .clk(clk), .rst(rst), .load(cfg_load),
      .base_hi(tbl_base_hi), .len_raw(tbl_len), .buf_raw(buf_base),
      .tbl_base(tbl_base_e), .len_eff(len_e), .buf_base(buf_base_e)
   );

   ttseq_addr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W),
      .ENTRY_BYTES(ENTRY_BYTES), .BUF_BYTES(BUF_BYTES)
   ) u_addr (
      .idx(idx), .tbl_base(tbl_base_e), .buf_base(buf_base_e),
      .rd_addr(rd_addr), .dst_addr(dst_addr)
   );

   ttseq_decode u_dec (
      .word(mem_rdata), .vld(dec_vld), .slot(dec_slot),
      .stream(dec_stream), .rsvd_bad(dec_rsvd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         idx      <= '0;
         slot_q   <= '0;
         stream_q <= '0;
         err_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (frame_start) begin
                  state <= ST_READ;
                  idx   <= '0;
               end
            end
            ST_READ: begin
               if (mem_ack) begin
                  slot_q   <= dec_slot;
                  stream_q <= dec_stream;
                  if (dec_rsvd) err_q <= 1'b1;
                  if (dec_vld) begin
                     state <= ST_CMD;
                  end else if (at_last) begin
                     state <= ST_IDLE;
                     idx   <= '0;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            ST_CMD: begin
               if (cmd_ready) begin
                  if (at_last) begin
                     state <= ST_IDLE;
                     idx   <= '0;
                  end else begin
                     state <= ST_READ;
                     idx   <= idx + IDX_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req    = (state == ST_READ);
   assign mem_addr   = rd_addr;
   assign cmd_valid  = (state == ST_CMD);
   assign cmd_stream = stream_q;
   assign cmd_slot   = slot_q;
   assign cmd_index  = idx;
   assign cmd_addr   = dst_addr;
   assign rsvd_err   = err_q;

   p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_first_read_r3: assert property (@(posedge clk) disable iff (rst)
      (!mem_req && !cmd_valid && frame_start) |=> (mem_req && (mem_addr == tbl_base_e)));

   p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && !mem_req && $stable(cmd_index)
                                     && $stable(cmd_slot) && $stable(cmd_stream)
                                     && $stable(cmd_addr)));

   p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
      cmd_valid |-> (LEN_W'(cmd_index) < len_e));

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      rsvd_err |=> rsvd_err);

   p_no_cmd_on_invalid_r5: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_ack && !mem_rdata[WORD_W-1]) |=> !cmd_valid);
endmodule

// File: tb/tdm_tx_table_seq_test.sv
module tdm_tx_table_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        frame_start = 1'b0;
   logic [11:0] tbl_base_hi = '0;
   logic [11:0] tbl_len = 12'd128;
   logic [20:0] buf_base = '0;
   logic        mem_req;
   logic [20:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [3:0]  cmd_stream;
   logic [6:0]  cmd_slot;
   logic [10:0] cmd_index;
   logic [20:0] cmd_addr;
   logic        rsvd_err;

   int n_tests = 0;
   int n_fail  = 0;
   int pat = 0;
   int lat = 0;
   int rmode = 0;
   int stall_ctr = 0;
   bit done = 0;
   logic [20:0] exp_rd[$];
   logic [42:0] exp_cmd[$];

   always #2 clk = ~clk;

   tdm_tx_table_seq uut (
      .clk(clk), .rst(rst), .frame_start(frame_start),
      .tbl_base_hi(tbl_base_hi), .tbl_len(tbl_len), .buf_base(buf_base),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_stream(cmd_stream),
      .cmd_slot(cmd_slot), .cmd_index(cmd_index), .cmd_addr(cmd_addr),
      .rsvd_err(rsvd_err)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] entry_at(input logic [20:0] a);
      logic [31:0] n, h;
      logic        v;
      logic [3:0]  r;
      n = 32'(a[11:1]);
      h = n * 37 + 32'(pat) * 11 + 5;
      r = 4'h0;
      case (pat)
         0: v = 1'b1;
         1: v = n[0];
         2: v = (n % 5) == 0;
         default: begin
            v = ~n[1];
            if ((n % 7) == 0) r = 4'hA;
         end
      endcase
      return {v, r, h[6:0], h[10:7]};
   endfunction

   // memory responder
   initial begin
      int wait_cnt = 0;
      logic [20:0] prev_addr = '0;
      forever begin
         @(negedge clk);
         if (rst) begin
            mem_ack = 1'b0; wait_cnt = 0;
         end else if (mem_ack) begin
            mem_ack = 1'b0; wait_cnt = 0;
         end else if (mem_req) begin
            if (wait_cnt > 0)
               chk(mem_addr == prev_addr, "R2 addr stable", 64'(mem_addr), 64'(prev_addr));
            if (wait_cnt >= lat) begin
               if (exp_rd.size() == 0) begin
                  chk(1'b0, "R7/R8 unexpected read", 64'(mem_addr), 64'h0);
               end else begin
                  logic [20:0] e;
                  e = exp_rd.pop_front();
                  chk(mem_addr == e, "R2/R3 read address", 64'(mem_addr), 64'(e));
               end
               mem_rdata = entry_at(mem_addr);
               mem_ack = 1'b1;
               wait_cnt = 0;
            end else begin
               wait_cnt++;
            end
            prev_addr = mem_addr;
         end
      end
   end

   // command sink
   initial begin
      forever begin
         @(negedge clk);
         cmd_ready = 1'b0;
         if (!rst && cmd_valid) begin
            if (exp_cmd.size() == 0) begin
               chk(1'b0, "R5 unexpected command", 64'(cmd_index), 64'h0);
            end else begin
               logic [42:0] e;
               e = exp_cmd[0];
               chk({cmd_stream, cmd_slot, cmd_index, cmd_addr} == e,
                   "R4/R6/R9/R10 command fields",
                   64'({cmd_stream, cmd_slot, cmd_index, cmd_addr}), 64'(e));
            end
            stall_ctr++;
            if (rmode == 0 || (stall_ctr % 3) == 2) begin
               cmd_ready = 1'b1;
               if (exp_cmd.size() != 0) void'(exp_cmd.pop_front());
            end
         end
      end
   end

   task automatic run_frame(input logic [11:0] bhi, input int len_req, input logic [20:0] bufb,
                            input int p, input int l, input int rm, input bit mid_change);
      int L;
      int guard;
      pat = p; lat = l; rmode = rm;
      L = (len_req < 128) ? 128 : (len_req > 2048) ? 2048 : len_req;
      for (int n = 0; n < L; n++) begin
         logic [20:0] a;
         logic [15:0] w;
         a = {bhi, 9'b0} + 21'(n * 2);
         exp_rd.push_back(a);
         w = entry_at(a);
         if (w[15]) exp_cmd.push_back({w[3:0], w[10:4], 11'(n), bufb + 21'(n * 64)});
      end
      @(negedge clk);
      tbl_base_hi = bhi; tbl_len = 12'(len_req); buf_base = bufb;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      if (mid_change) begin
         repeat (20) @(negedge clk);
         // R11: new config mid-walk; R8: stray frame start ignored
         tbl_base_hi = bhi + 12'd3; tbl_len = 12'd130; buf_base = bufb + 21'h40;
         frame_start = 1'b1;
         @(negedge clk);
         frame_start = 1'b0;
      end
      guard = 0;
      while ((exp_rd.size() != 0 || exp_cmd.size() != 0) && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      chk(exp_rd.size() == 0, "R7 all entries read", 64'(exp_rd.size()), 64'h0);
      chk(exp_cmd.size() == 0, "R4 all commands seen", 64'(exp_cmd.size()), 64'h0);
      repeat (3) @(negedge clk);
      repeat (5) begin
         @(negedge clk);
         chk(!mem_req && !cmd_valid, "R8 idle after last entry",
             64'({mem_req, cmd_valid}), 64'h0);
      end
      exp_rd.delete(); exp_cmd.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(!mem_req, "R1 no request after reset", 64'(mem_req), 64'h0);
      chk(!cmd_valid, "R1 no command after reset", 64'(cmd_valid), 64'h0);
      chk(!rsvd_err, "R1 error clear after reset", 64'(rsvd_err), 64'h0);
      repeat (10) @(negedge clk);
      chk(!mem_req && !cmd_valid, "R1 stays idle without frame start",
          64'({mem_req, cmd_valid}), 64'h0);

      run_frame(12'h012, 200, 21'h01_0000, 0, 0, 0, 1'b0);   // R3 R4 R6
      chk(!rsvd_err, "R10 clean table leaves flag clear", 64'(rsvd_err), 64'h0);
      run_frame(12'h100, 5, 21'h00_2000, 1, 1, 1, 1'b0);     // R5 R7 low clamp, R9 stalls
      run_frame(12'hFFF, 3000, 21'h1F_F000, 0, 0, 0, 1'b0);  // R7 high clamp, R2 R6 wrap
      run_frame(12'h020, 300, 21'h00_0400, 2, 2, 1, 1'b1);   // R11 R8 mid-walk change
      run_frame(12'h033, 150, 21'h00_8000, 3, 0, 1, 1'b0);   // R10 reserved bits
      chk(rsvd_err, "R10 flag set by reserved bits", 64'(rsvd_err), 64'h1);
      run_frame(12'h044, 128, 21'h00_0000, 0, 1, 0, 1'b0);
      chk(rsvd_err, "R10 flag sticky", 64'(rsvd_err), 64'h1);

      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      chk(!rsvd_err && !mem_req && !cmd_valid, "R1 reset clears flag and walk",
          64'({rsvd_err, mem_req, cmd_valid}), 64'h0);
      run_frame(12'h005, 129, 21'h00_1000, 1, 0, 0, 1'b0);   // R3 restart at entry 0

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         chk(1'b0, "watchdog", 64'h0, 64'h1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule